// File: doc/BRIEF.md
# Power Mode Clock Controller

This block decides, every cycle, which clock domains of a processor are allowed to tick. It drives four enables: one for the instruction-execution core, one for the bus-interface logic, one for the on-chip peripherals and one for the crystal oscillator. The enables are consumed by clock-gating cells outside this block. Any domain that is frozen has its enable held low, so its gated clock parks at logic zero.

Software asks for a mode with a two-bit command code. Three modes reduce power. Slow mode lets all three logic domains tick once every N input clocks, with N chosen by a two-bit field. Idle mode stops the core and the bus interface while the peripherals keep running. Powerdown stops every domain and turns the oscillator off. Each mode has its own wake conditions: an unmasked interrupt, a non-maskable interrupt, or a synchronous reset. Leaving powerdown passes through a settle phase that models the oscillator start-up. The settle phase lasts for a count that software programs.

Top module: `pwrclk_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters run mode (`mode_stat` = 0) with `core_en`, `bus_en`, `periph_en` and `osc_en` all high from the next cycle on.
- R2: `mode_stat` encodes run=0, slow=1, idle=2, powerdown=3, settling=4. `cmd_code` encodes run=00, slow=01, idle=10, powerdown=11. In run mode, a command sampled with `cmd_valid` high takes effect at that same clock edge.
- R3: In slow mode, `core_en`, `bus_en` and `periph_en` are high for the first cycle of each period of N cycles and low for the other N-1 cycles. `div_sel` is 00 for N=1, 01 for N=4, 10 for N=8 and 11 for N=16, and it is sampled when the slow-mode command is accepted. With N=1 the enables stay high.
- R4: A mode change out of slow mode happens only at the clock edge that ends a period. A command sampled in the pulse cycle of a period therefore leaves N-1 further slow cycles with the enables low before the new mode is entered, and no enable pulse is ever cut short.
- R5: In slow mode, a pulse on `irq` or `nmi` returns the block to run mode at the end of the current period. This wake wins over any command seen in the same period.
- R6: In idle mode, `core_en` and `bus_en` are low while `periph_en` and `osc_en` stay high.
- R7: In idle mode, `irq` or `nmi` high at a clock edge returns the block to run mode at that edge.
- R8: In powerdown mode, all four enables are low, and `irq` has no effect.
- R9: In powerdown mode, `nmi` high at a clock edge starts the settling mode. Settling lasts `settle_cnt`+1 cycles with only `osc_en` high, and the block then enters run mode with all enables high.
- R10: Commands are ignored in idle, powerdown and settling modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Mode command strobe |
| cmd_code | input | 2 | Requested mode |
| div_sel | input | 2 | Slow-mode divisor code |
| settle_cnt | input | SETTLE_W | Oscillator settle length in cycles |
| irq | input | 1 | Unmasked maskable interrupt pending |
| nmi | input | 1 | Non-maskable interrupt |
| core_en | output | 1 | Clock enable, execution core |
| bus_en | output | 1 | Clock enable, bus interface |
| periph_en | output | 1 | Clock enable, peripherals |
| osc_en | output | 1 | Oscillator enable |
| mode_stat | output | 3 | Current mode |

## Verification
A wrong phase count in slow mode changes the spacing of the enable pulses. It shows at the enables within one period, at most 16 cycles. A mode decision that is held pending incorrectly shows in `mode_stat`. The status changes either one cycle early, cutting a period short, or it never changes at all, and the wait loops in the bench catch both. A fault in the settle counter shifts the cycle in which all enables return high after powerdown. The bench therefore counts the settling cycles exactly, for a long and for a zero settle length.

// File: rtl/pwrclk_pkg.sv
package pwrclk_pkg;

    localparam int STAT_W = 3;
    localparam int CMD_W  = 2;
    localparam int DSEL_W = 2;
    localparam int PH_W   = 4;

    typedef enum logic [STAT_W-1:0] {
        PM_RUN  = 3'd0,
        PM_SLOW = 3'd1,
        PM_IDLE = 3'd2,
        PM_DOWN = 3'd3,
        PM_WAKE = 3'd4
    } pmode_t;

    typedef struct packed {
        logic              valid;
        logic              wake;
        pmode_t            mode;
        logic [DSEL_W-1:0] dsel;
    } preq_t;

    typedef struct packed {
        logic core;
        logic bus;
        logic periph;
        logic osc;
    } en_t;

    function automatic logic [PH_W-1:0] div_last(input logic [DSEL_W-1:0] s);
        logic [PH_W-1:0] r;
        case (s)
            2'd0:    r = 4'd0;
            2'd1:    r = 4'd3;
            2'd2:    r = 4'd7;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

    function automatic pmode_t cmd_to_mode(input logic [CMD_W-1:0] c);
        pmode_t m;
        case (c)
            2'd0:    m = PM_RUN;
            2'd1:    m = PM_SLOW;
            2'd2:    m = PM_IDLE;
            default: m = PM_DOWN;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwrclk_divider.sv
module pwrclk_divider
    import pwrclk_pkg::*;
#(
    parameter int W = PH_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         active,
    input  logic [W-1:0] last,
    output logic         phase_zero,
    output logic         at_end
);

    logic [W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (active) begin
            if (phase == last) phase <= '0;
            else               phase <= phase + 1'b1;
        end
    end

    assign phase_zero = (phase == '0);
    assign at_end     = (phase == last);

endmodule

// File: rtl/pwrclk_settle.sv
module pwrclk_settle #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         active,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                        cnt <= '0;
        else if (load)                  cnt <= load_val;
        else if (active && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pwrclk_endec.sv
module pwrclk_endec
    import pwrclk_pkg::*;
(
    input  pmode_t mode,
    input  logic   phase_zero,
    output en_t    en
);

    always_comb begin
        en = '0;
        unique case (mode)
            PM_RUN:  en = '{core: 1'b1, bus: 1'b1, periph: 1'b1, osc: 1'b1};
            PM_SLOW: en = '{core: phase_zero, bus: phase_zero, periph: phase_zero, osc: 1'b1};
            PM_IDLE: en = '{core: 1'b0, bus: 1'b0, periph: 1'b1, osc: 1'b1};
            PM_WAKE: en = '{core: 1'b0, bus: 1'b0, periph: 1'b0, osc: 1'b1};
            default: en = '0;
        endcase
    end

endmodule

// File: rtl/pwrclk_fsm.sv
module pwrclk_fsm
    import pwrclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [DSEL_W-1:0] div_sel,
    input  logic              irq,
    input  logic              nmi,
    input  logic              at_end,
    input  logic              settle_done,
    output pmode_t            mode,
    output logic [PH_W-1:0]   slow_last,
    output logic              slow_restart,
    output logic              wake_load
);

    pmode_t          mode_n;
    preq_t           pend, pend_n, req;
    logic [PH_W-1:0] slow_last_n;
    logic            accept;
    logic            commit;

    always_comb begin
        accept = cmd_valid && (mode == PM_RUN || mode == PM_SLOW);
        req    = pend;
        if (accept && !pend.wake) begin
            req = '{valid: 1'b1, wake: 1'b0, mode: cmd_to_mode(cmd_code), dsel: div_sel};
        end
        if (mode == PM_SLOW && (irq || nmi)) begin
            req = '{valid: 1'b1, wake: 1'b1, mode: PM_RUN, dsel: req.dsel};
        end
    end

    always_comb begin
        mode_n       = mode;
        pend_n       = pend;
        slow_last_n  = slow_last;
        commit       = 1'b0;
        slow_restart = 1'b0;
        wake_load    = 1'b0;
        unique case (mode)
            PM_RUN:  commit = 1'b1;
            PM_SLOW: begin
                commit = at_end;
                if (!at_end) pend_n = req;
            end
            PM_IDLE: if (irq || nmi) mode_n = PM_RUN;
            PM_DOWN: if (nmi) begin
                mode_n    = PM_WAKE;
                wake_load = 1'b1;
            end
            PM_WAKE: if (settle_done) mode_n = PM_RUN;
            default: mode_n = PM_RUN;
        endcase
        if (commit) begin
            pend_n = '0;
            if (req.valid) begin
                mode_n = req.mode;
                if (req.mode == PM_SLOW) begin
                    slow_last_n  = div_last(req.dsel);
                    slow_restart = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= PM_RUN;
            pend      <= '0;
            slow_last <= '0;
        end else begin
            mode      <= mode_n;
            pend      <= pend_n;
            slow_last <= slow_last_n;
        end
    end

endmodule

// File: rtl/pwrclk_ctrl.sv
module pwrclk_ctrl
    import pwrclk_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_code,
    input  logic [1:0]          div_sel,
    input  logic [SETTLE_W-1:0] settle_cnt,
    input  logic                irq,
    input  logic                nmi,
    output logic                core_en,
    output logic                bus_en,
    output logic                periph_en,
    output logic                osc_en,
    output logic [2:0]          mode_stat
);

    pmode_t          mode;
    logic [PH_W-1:0] slow_last;
    logic            slow_restart;
    logic            wake_load;
    logic            phase_zero;
    logic            at_end;
    logic            settle_done;
    en_t             en;

    pwrclk_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .div_sel      (div_sel),
        .irq          (irq),
        .nmi          (nmi),
        .at_end       (at_end),
        .settle_done  (settle_done),
        .mode         (mode),
        .slow_last    (slow_last),
        .slow_restart (slow_restart),
        .wake_load    (wake_load)
    );

    pwrclk_divider #(.W(PH_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .restart    (slow_restart),
        .active     (mode == PM_SLOW),
        .last       (slow_last),
        .phase_zero (phase_zero),
        .at_end     (at_end)
    );

    pwrclk_settle #(.W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (wake_load),
        .load_val (settle_cnt),
        .active   (mode == PM_WAKE),
        .done     (settle_done)
    );

    pwrclk_endec u_endec (
        .mode       (mode),
        .phase_zero (phase_zero),
        .en         (en)
    );

    assign core_en   = en.core;
    assign bus_en    = en.bus;
    assign periph_en = en.periph;
    assign osc_en    = en.osc;
    assign mode_stat = mode;

endmodule

// File: rtl/pwrclk_chk.sv
module pwrclk_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       nmi,
    input logic       core_en,
    input logic       bus_en,
    input logic       periph_en,
    input logic       osc_en,
    input logic [2:0] mode_stat,
    input logic [3:0] slow_last
);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (mode_stat == 3'd0 && core_en && bus_en && periph_en && osc_en));

    // R4
    slow_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 3'd1 && core_en && slow_last != 4'd0) |=> (mode_stat == 3'd1));

    // R6
    idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 3'd2) |-> (!core_en && !bus_en && periph_en && osc_en));

    // R7
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 3'd2 && (irq || nmi)) |=> (mode_stat == 3'd0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 3'd2 && !irq && !nmi) |=> (mode_stat == 3'd2));

    // R8
    down_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 3'd3) |-> (!core_en && !bus_en && !periph_en && !osc_en));

    // R8
    down_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 3'd3 && !nmi) |=> (mode_stat == 3'd3));

    // R9
    wake_osc_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_stat == 3'd4) |-> (osc_en && !core_en && !bus_en && !periph_en));

endmodule

bind pwrclk_ctrl pwrclk_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .nmi       (nmi),
    .core_en   (core_en),
    .bus_en    (bus_en),
    .periph_en (periph_en),
    .osc_en    (osc_en),
    .mode_stat (mode_stat),
    .slow_last (slow_last)
);

// File: tb/pwrclk_ctrl_bench.sv
module pwrclk_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic [1:0] div_sel = 2'd0;
    logic [7:0] settle_cnt = 8'd0;
    logic       irq = 1'b0;
    logic       nmi = 1'b0;
    logic       core_en, bus_en, periph_en, osc_en;
    logic [2:0] mode_stat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwrclk_ctrl #(.SETTLE_W(8)) u_pwrclk_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .div_sel    (div_sel),
        .settle_cnt (settle_cnt),
        .irq        (irq),
        .nmi        (nmi),
        .core_en    (core_en),
        .bus_en     (bus_en),
        .periph_en  (periph_en),
        .osc_en     (osc_en),
        .mode_stat  (mode_stat)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ens();
        return {core_en, bus_en, periph_en, osc_en};
    endfunction

    task automatic send(input logic [1:0] code, input logic [1:0] dsel);
        cmd_valid = 1'b1; cmd_code = code; div_sel = dsel;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_leave(input logic [2:0] m, output int cyc);
        cyc = 0;
        while (mode_stat == m && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mode", mode_stat, 0);
        check("R1 reset enables", ens(), 4'b1111);
    endtask

    task automatic t_slow(input logic [1:0] dsel, input int n);
        int hi, cyc;
        send(2'd1, dsel);
        check("R2 slow status", mode_stat, 1);
        hi = 0;
        for (int i = 0; i < 2 * n; i++) begin
            check("R3 slow pulse position", core_en, (i % n) == 0);
            if (core_en && bus_en && periph_en) hi++;
            @(negedge clk);
        end
        check("R3 pulses in two periods", hi, 2);
        send(2'd0, 2'd0);
        wait_leave(3'd1, cyc);
        check("R4 cycles before leaving slow", cyc, n - 1);
        check("R2 back to run", mode_stat, 0);
        check("R2 run enables", ens(), 4'b1111);
    endtask

    task automatic t_slow_wake(input bit use_nmi);
        int cyc;
        send(2'd1, 2'd2);
        irq = !use_nmi; nmi = use_nmi;
        cmd_valid = 1'b1; cmd_code = 2'd3;
        @(negedge clk);
        irq = 1'b0; nmi = 1'b0; cmd_valid = 1'b0;
        wait_leave(3'd1, cyc);
        check("R5 wake at period end", cyc, 7);
        check("R5 wake beats command", mode_stat, 0);
    endtask

    task automatic t_idle();
        send(2'd2, 2'd0);
        check("R6 idle status", mode_stat, 2);
        check("R6 idle enables", ens(), 4'b0011);
        send(2'd3, 2'd0);
        repeat (3) @(negedge clk);
        check("R10 command ignored in idle", mode_stat, 2);
        check("R10 oscillator kept in idle", osc_en, 1);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check("R7 idle exit on irq", mode_stat, 0);
        send(2'd2, 2'd0);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        check("R7 idle exit on nmi", mode_stat, 0);
    endtask

    task automatic t_down(input int s);
        int cyc, bad;
        settle_cnt = s[7:0];
        send(2'd3, 2'd0);
        check("R8 powerdown status", mode_stat, 3);
        check("R8 powerdown enables", ens(), 0);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        send(2'd0, 2'd0);
        repeat (2) @(negedge clk);
        check("R8 irq ignored in powerdown", mode_stat, 3);
        check("R10 command ignored in powerdown", ens(), 0);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        cmd_valid = 1'b1; cmd_code = 2'd2;
        cyc = 0; bad = 0;
        while (mode_stat == 3'd4 && cyc < 300) begin
            if (ens() != 4'b0001) bad++;
            cyc++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check("R9 settle length", cyc, s + 1);
        check("R9 only oscillator while settling", bad, 0);
        check("R9 run after settle", mode_stat, 0);
        check("R9 enables after settle", ens(), 4'b1111);
    endtask

    task automatic t_reset_mid();
        send(2'd3, 2'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset from powerdown mode", mode_stat, 0);
        check("R1 reset from powerdown enables", ens(), 4'b1111);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_slow(2'd1, 4);
        t_slow(2'd2, 8);
        t_slow(2'd3, 16);
        t_slow(2'd0, 1);
        t_slow_wake(1'b0);
        t_slow_wake(1'b1);
        t_idle();
        t_down(5);
        t_down(0);
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule